// File: doc/BRIEF.md
# Multiphase Power Zone Sequencer

The sequencer chooses which of five power zones a multiphase regulator runs in and turns that zone into a per-phase enable mask. Zone 0 drives every populated phase. Zones 1 and 2 thin the phases out. Zone 3 runs one phase in continuous conduction, and zone 4 runs one phase in discontinuous conduction. A three-level mode input, already decoded into two bits, selects one of three behaviours. Full mode pins the zone at 0. Automatic mode derives the zone from a total-current sample taken on each 10 ms tick. Fixed mode follows a programmed zone register.

Zone moves are deliberately asymmetric. A move toward a lower zone number, which means more phases, happens immediately, one zone per clock. A move toward a higher zone number waits a programmable number of ticks before each single step. Both directions pass through every intermediate zone that is enabled. In automatic mode, hysteresis applies before any zone is shed. A threshold register holding all ones removes its zone from automatic use. Until the output-nominal flag is seen, the mode input is frozen at its value just after reset and automatic shedding stays off.

Top module: `pzone_seq`

## Requirements
- R1: After reset, zone_o is 0, dcm_o is 0 and pwm_en enables phases 1 up to phase_cnt.
- R2: With mode_in = 2'b10 or 2'b11 (full), the zone moves to 0 and stays there whatever the current.
- R3: With mode_in = 2'b01 (automatic) after nominal, i_sample is captured only on tick_10ms. Zone k (0 to 3) is the target when the sample exceeds the limit of zone k (lim4 for zone 0, lim3 for zone 1, lim2 for zone 2, lim1 for zone 3) and exceeds no lower-numbered zone's limit. Zone 4 is the target otherwise.
- R4: A target below the current zone number is approached one enabled zone per clock, without waiting for ticks.
- R5: A target above the current zone number is approached one enabled zone per step. Each step happens on the shed_dly-th tick after the previous step, or after the step was first requested.
- R6: In automatic mode, a zone is shed only once the sample falls below that zone's limit minus hyst (saturating at 0).
- R7: A limit equal to all ones disables its zone for automatic mode. Such a zone is never the target and is skipped while stepping.
- R8: With mode_in = 2'b00 (fixed), the target is zone_boot until the mode has been non-fixed after nominal. From then on the target is zone_run.
- R9: In fixed mode, a requested zone is reached even when its limit disables it for automatic mode.
- R10: Before v_nominal has been seen, changes on mode_in are ignored, and automatic mode holds zone 0.
- R11: In 8-phase terms, zone 0 enables all phases, zone 1 enables phases 1/3/5/7 (pwm_en = 0x55), zone 2 enables phases 1/5 (0x11), and zones 3 and 4 enable phase 1 (0x01). Bits at or above phase_cnt are cleared.
- R12: dcm_o is 1 exactly when the zone is 4.
- R13: The shed countdown restarts when the target returns to the current zone before the count expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_in | input | 2 | Decoded mode: 00 fixed, 01 automatic, 1x full |
| i_sample | input | CUR_W | Digitized total output current |
| lim1 | input | CUR_W | Limit for zone 3 (lowest) |
| lim2 | input | CUR_W | Limit for zone 2 |
| lim3 | input | CUR_W | Limit for zone 1 |
| lim4 | input | CUR_W | Limit for zone 0 (highest) |
| hyst | input | CUR_W | Shedding hysteresis |
| shed_dly | input | DLY_W | Ticks before each shed step |
| zone_boot | input | 3 | Fixed zone before the mode has left fixed |
| zone_run | input | 3 | Fixed zone afterwards |
| v_nominal | input | 1 | Output has reached its nominal voltage |
| phase_cnt | input | PC_W | Number of populated phases (1 to NPH) |
| tick_10ms | input | 1 | One-cycle timebase pulse |
| zone_o | output | 3 | Current power zone |
| pwm_en | output | NPH | Per-phase enable, bit 0 is phase 1 |
| dcm_o | output | 1 | Discontinuous-mode flag |

## Verification
The hardest situation to reach is a pending shed step that must be abandoned and restarted. That takes a low sample, partial tick progress, a return of the target to the current zone, and then a new request, each timed against the tick that both captures the sample and decrements the counter. The bench drives ticks one at a time through a task and changes i_sample between them. It then checks that the zone still holds on the tick where an unrestarted counter would already have stepped, and that the zone moves one tick later. The fixed-mode path from boot zone to run zone is reached by a dedicated reset: it holds mode_in fixed before nominal, raises full mode and then returns to fixed.

// File: rtl/pzone_pkg.sv
package pzone_pkg;
  typedef logic [2:0] zone_t;

  localparam zone_t ZONE_MAX = 3'd4;

  typedef enum logic [1:0] {
    MD_FIXED = 2'b00,
    MD_AUTO  = 2'b01,
    MD_FULL  = 2'b10
  } mode_t;

  typedef enum logic [1:0] {
    SEL_FULL  = 2'b00,
    SEL_AUTO  = 2'b01,
    SEL_FIXED = 2'b10
  } tsel_t;
endpackage

// File: rtl/pzone_target.sv
module pzone_target
  import pzone_pkg::*;
#(
  parameter int CUR_W = 8
) (
  input  logic [CUR_W-1:0]      cur_q,
  input  logic [3:0][CUR_W-1:0] lim_v,   // index = zone whose limit it is
  input  logic [CUR_W-1:0]      hyst,
  input  zone_t                 zone,
  input  tsel_t                 tsel,
  input  zone_t                 fixed_zone,
  output zone_t                 target,
  output logic [4:0]            zen
);
  localparam logic [CUR_W-1:0] OFF = {CUR_W{1'b1}};

  function automatic logic [CUR_W-1:0] sat_sub(input logic [CUR_W-1:0] a,
                                                input logic [CUR_W-1:0] b);
    return (a > b) ? a - b : '0;
  endfunction

  // lowest enabled zone whose limit the sample exceeds
  function automatic zone_t pick_rise(input logic [CUR_W-1:0] c,
                                      input logic [3:0][CUR_W-1:0] l,
                                      input logic [3:0] en);
    zone_t r = ZONE_MAX;
    for (int k = 3; k >= 0; k--)
      if (en[k] && c > l[k]) r = 3'(k);
    return r;
  endfunction

  // same picker with limits lowered by the hysteresis
  function automatic zone_t pick_fall(input logic [CUR_W-1:0] c,
                                      input logic [3:0][CUR_W-1:0] l,
                                      input logic [CUR_W-1:0] h,
                                      input logic [3:0] en);
    zone_t r = ZONE_MAX;
    for (int k = 3; k >= 0; k--)
      if (en[k] && c >= sat_sub(l[k], h)) r = 3'(k);
    return r;
  endfunction

  logic [3:0] lim_en;
  zone_t      z_rise, z_fall, fix_c;

  for (genvar k = 0; k < 4; k++) begin : g_en
    assign lim_en[k] = (lim_v[k] != OFF);
  end
  assign zen = {1'b1, lim_en};

  assign z_rise = pick_rise(cur_q, lim_v, lim_en);
  assign z_fall = pick_fall(cur_q, lim_v, hyst, lim_en);
  assign fix_c  = (fixed_zone > ZONE_MAX) ? ZONE_MAX : fixed_zone;

  always_comb begin
    unique case (tsel)
      SEL_AUTO: begin
        if (z_rise < zone)      target = z_rise;
        else if (z_fall > zone) target = z_fall;
        else                    target = zone;
      end
      SEL_FIXED: target = fix_c;
      default:   target = '0;
    endcase
  end
endmodule

// File: rtl/pzone_stepper.sv
module pzone_stepper
  import pzone_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  zone_t            target,
  input  logic [4:0]       zen,
  input  logic [DLY_W-1:0] shed_dly,
  output zone_t            zone,
  output logic             step_dn,
  output logic             step_up
);
  // highest usable zone strictly between target and current (going down)
  function automatic zone_t next_dn(input zone_t z, input zone_t t, input logic [4:0] en);
    zone_t r = t;
    for (int k = 0; k <= 4; k++)
      if (3'(k) < z && 3'(k) > t && en[k]) r = 3'(k);
    return r;
  endfunction

  // lowest usable zone strictly between current and target (going up)
  function automatic zone_t next_up(input zone_t z, input zone_t t, input logic [4:0] en);
    zone_t r = t;
    for (int k = 4; k >= 0; k--)
      if (3'(k) > z && 3'(k) < t && en[k]) r = 3'(k);
    return r;
  endfunction

  logic [DLY_W-1:0] cnt;
  logic             pend;
  logic             want_up;

  assign step_dn = (target < zone);
  assign want_up = (target > zone);
  assign step_up = want_up && pend && tick && (cnt <= DLY_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone <= '0;
      cnt  <= '0;
      pend <= 1'b0;
    end else if (step_dn) begin
      zone <= next_dn(zone, target, zen);
      pend <= 1'b0;
    end else if (want_up) begin
      if (!pend) begin
        pend <= 1'b1;
        cnt  <= shed_dly;
      end else if (step_up) begin
        zone <= next_up(zone, target, zen);
        cnt  <= shed_dly;
      end else if (tick) begin
        cnt <= cnt - DLY_W'(1);
      end
    end else begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pzone_mask.sv
module pzone_mask
  import pzone_pkg::*;
#(
  parameter int NPH  = 8,
  parameter int PC_W = 4
) (
  input  zone_t           zone,
  input  logic [PC_W-1:0] phase_cnt,
  output logic [NPH-1:0]  pwm_en
);
  // phase p (0-based) runs in zone z
  function automatic logic runs_in(input int p, input zone_t z);
    case (z)
      3'd0:    return 1'b1;
      3'd1:    return (p % 2) == 0;
      3'd2:    return (p % 4) == 0;
      default: return p == 0;
    endcase
  endfunction

  logic [PC_W-1:0] pc_eff;
  assign pc_eff = (phase_cnt == '0) ? PC_W'(1) : phase_cnt;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    assign pwm_en[p] = runs_in(p, zone) && (PC_W'(p) < pc_eff);
  end
endmodule

// File: rtl/pzone_seq.sv
module pzone_seq
  import pzone_pkg::*;
#(
  parameter int CUR_W = 8,
  parameter int DLY_W = 8,
  parameter int NPH   = 8,
  localparam int PC_W = $clog2(NPH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_in,
  input  logic [CUR_W-1:0] i_sample,
  input  logic [CUR_W-1:0] lim1,
  input  logic [CUR_W-1:0] lim2,
  input  logic [CUR_W-1:0] lim3,
  input  logic [CUR_W-1:0] lim4,
  input  logic [CUR_W-1:0] hyst,
  input  logic [DLY_W-1:0] shed_dly,
  input  logic [2:0]       zone_boot,
  input  logic [2:0]       zone_run,
  input  logic             v_nominal,
  input  logic [PC_W-1:0]  phase_cnt,
  input  logic             tick_10ms,
  output logic [2:0]       zone_o,
  output logic [NPH-1:0]   pwm_en,
  output logic             dcm_o
);
  logic                  init_done, nom_seen, run_sel;
  logic [1:0]            mode_eff;
  logic [CUR_W-1:0]      cur_q;
  logic [3:0][CUR_W-1:0] lim_v;
  tsel_t                 tsel;
  zone_t                 target, zone, fixed_zone;
  logic [4:0]            zen;
  logic                  step_dn, step_up, force_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_done <= 1'b0;
      nom_seen  <= 1'b0;
      run_sel   <= 1'b0;
      mode_eff  <= MD_FULL;
      cur_q     <= '0;
    end else begin
      init_done <= 1'b1;
      if (v_nominal) nom_seen <= 1'b1;
      if (!init_done || v_nominal || nom_seen) mode_eff <= mode_in;
      if (tick_10ms) cur_q <= i_sample;
      if (nom_seen && mode_eff != MD_FIXED) run_sel <= 1'b1;
    end
  end

  assign lim_v      = {lim1, lim2, lim3, lim4};  // [0]=zone 0 limit
  assign fixed_zone = run_sel ? zone_run : zone_boot;

  always_comb begin
    if (mode_eff == MD_FIXED)                tsel = SEL_FIXED;
    else if (mode_eff == MD_AUTO && nom_seen) tsel = SEL_AUTO;
    else                                     tsel = SEL_FULL;
  end
  assign force_full = (tsel == SEL_FULL);

  pzone_target #(.CUR_W(CUR_W)) u_tgt (
    .cur_q(cur_q), .lim_v(lim_v), .hyst(hyst), .zone(zone),
    .tsel(tsel), .fixed_zone(fixed_zone), .target(target), .zen(zen)
  );

  pzone_stepper #(.DLY_W(DLY_W)) u_step (
    .clk(clk), .rst_n(rst_n), .tick(tick_10ms), .target(target), .zen(zen),
    .shed_dly(shed_dly), .zone(zone), .step_dn(step_dn), .step_up(step_up)
  );

  pzone_mask #(.NPH(NPH), .PC_W(PC_W)) u_mask (
    .zone(zone), .phase_cnt(phase_cnt), .pwm_en(pwm_en)
  );

  assign zone_o = zone;
  assign dcm_o  = (zone == ZONE_MAX);
endmodule

// File: rtl/pzone_seq_chk.sv
module pzone_seq_chk #(
  parameter int NPH  = 8,
  parameter int PC_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic [2:0]      zone,
  input logic            step_dn,
  input logic            step_up,
  input logic            force_full,
  input logic [NPH-1:0]  pwm_en,
  input logic [PC_W-1:0] phase_cnt
);
  a_r1_zone_range: assert property (@(posedge clk) disable iff (!rst_n)
    zone <= 3'd4);

  // R5: shedding only ever happens on a tick
  a_r5_up_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> zone <= $past(zone));

  a_r5_up_event: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> zone > $past(zone));

  a_r4_dn_now: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> zone < $past(zone));

  a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (force_full && zone == 3'd0) |=> zone == 3'd0);

  a_r11_phase1_on: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en[0]);

  a_r11_above_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_cnt != '0 && phase_cnt <= PC_W'(NPH)) |-> (pwm_en >> phase_cnt) == '0);
endmodule

bind pzone_seq pzone_seq_chk #(.NPH(NPH), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_10ms), .zone(zone_o),
  .step_dn(step_dn), .step_up(step_up), .force_full(force_full),
  .pwm_en(pwm_en), .phase_cnt(phase_cnt)
);

// File: tb/pzone_seq_bench.sv
module pzone_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_in = 2'b10;
  logic [7:0] i_sample = 8'h00;
  logic [7:0] lim1 = 8'h40, lim2 = 8'h80, lim3 = 8'hA0, lim4 = 8'hC0;
  logic [7:0] hyst = 8'h10;
  logic [7:0] shed_dly = 8'd1;
  logic [2:0] zone_boot = 3'd0, zone_run = 3'd0;
  logic       v_nominal = 1'b0;
  logic [3:0] phase_cnt = 4'd8;
  logic       tick_10ms = 1'b0;
  logic [2:0] zone_o;
  logic [7:0] pwm_en;
  logic       dcm_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pzone_seq u_pzone_seq (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .i_sample(i_sample),
    .lim1(lim1), .lim2(lim2), .lim3(lim3), .lim4(lim4), .hyst(hyst),
    .shed_dly(shed_dly), .zone_boot(zone_boot), .zone_run(zone_run),
    .v_nominal(v_nominal), .phase_cnt(phase_cnt), .tick_10ms(tick_10ms),
    .zone_o(zone_o), .pwm_en(pwm_en), .dcm_o(dcm_o)
  );

  // {sample, expected zone} in automatic mode, shed delay of one tick
  localparam logic [15:0] VEC [9] = '{
    {8'hD0, 8'd0}, {8'h20, 8'd4}, {8'hA8, 8'd1}, {8'h60, 8'd3}, {8'hD0, 8'd0},
    {8'h88, 8'd2}, {8'h20, 8'd4}, {8'h60, 8'd3}, {8'hA8, 8'd1}
  };

  function automatic logic [7:0] want_mask(input int z, input int pc);
    logic [7:0] base;
    case (z)
      0:       base = 8'hFF;
      1:       base = 8'h55;
      2:       base = 8'h11;
      default: base = 8'h01;
    endcase
    return base & 8'((9'd1 << pc) - 9'd1);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      tick_10ms = 1'b1;
      @(negedge clk);
      tick_10ms = 1'b0;
      cyc(3);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(1);
    do_reset();
    chk("R1 zone", zone_o, 0);
    chk("R1 mask", pwm_en, 8'hFF);
    chk("R1 dcm", dcm_o, 0);

    for (int pc = 1; pc <= 8; pc++) begin
      phase_cnt = 4'(pc);
      cyc(1);
      chk("R11 mask vs phase count", pwm_en, want_mask(0, pc));
    end
    phase_cnt = 4'd8;

    v_nominal = 1'b1;
    mode_in = 2'b01;
    cyc(2);
    for (int v = 0; v < 9; v++) begin
      i_sample = VEC[v][15:8];
      tick_n(8);
      chk("R3 zone from sample", zone_o, int'(VEC[v][7:0]));
      chk("R11 zone mask", pwm_en, want_mask(int'(VEC[v][7:0]), 8));
      chk("R12 dcm", dcm_o, VEC[v][7:0] == 8'd4);
    end

    // R4: rising current walks down one zone per clock
    i_sample = 8'h20; tick_n(8);
    chk("R4 start", zone_o, 4);
    i_sample = 8'hD0;
    tick_10ms = 1'b1; @(negedge clk); tick_10ms = 1'b0;
    @(negedge clk);
    chk("R4 first step", zone_o, 3);
    cyc(3);
    chk("R4 reached", zone_o, 0);

    // R5: each shed step waits shed_dly ticks
    shed_dly = 8'd3;
    i_sample = 8'h20;
    tick_n(1);
    tick_n(2);
    chk("R5 still waiting", zone_o, 0);
    tick_n(1);
    chk("R5 first shed", zone_o, 1);
    tick_n(2);
    chk("R5 second wait", zone_o, 1);
    tick_n(1);
    chk("R5 second shed", zone_o, 2);
    i_sample = 8'hD0; tick_n(1); cyc(4);
    chk("R4 back to 0", zone_o, 0);

    // R13: countdown restarts after target returns
    i_sample = 8'h20; tick_n(1);
    tick_n(1);
    i_sample = 8'hD0; tick_n(1);
    i_sample = 8'h20; tick_n(1);
    tick_n(2);
    chk("R13 restarted count holds", zone_o, 0);
    tick_n(1);
    chk("R13 step after full count", zone_o, 1);
    i_sample = 8'hD0; tick_n(1); cyc(4);

    // R6: hysteresis
    shed_dly = 8'd1;
    i_sample = 8'hB8; tick_n(6);
    chk("R6 inside hysteresis", zone_o, 0);
    i_sample = 8'hA8; tick_n(6);
    chk("R6 below hysteresis", zone_o, 1);
    i_sample = 8'hD0; tick_n(2); cyc(2);

    // R7: disabled limit for zone 1 is skipped
    lim3 = 8'hFF;
    i_sample = 8'h88;
    tick_n(1);
    chk("R7 before step", zone_o, 0);
    tick_n(1);
    chk("R7 skips zone 1", zone_o, 2);

    // R8/R9/R10: fixed mode
    mode_in = 2'b00; v_nominal = 1'b0;
    zone_boot = 3'd2; zone_run = 3'd1;
    do_reset();
    tick_n(4);
    chk("R8 boot zone", zone_o, 2);
    mode_in = 2'b10; tick_n(4);
    chk("R10 mode ignored before nominal", zone_o, 2);
    mode_in = 2'b00; cyc(1);
    v_nominal = 1'b1; tick_n(4);
    chk("R8 run zone not yet", zone_o, 2);
    mode_in = 2'b10; cyc(6);
    chk("R2 full mode", zone_o, 0);
    i_sample = 8'h10; tick_n(3);
    chk("R2 full ignores current", zone_o, 0);
    mode_in = 2'b00; tick_n(4);
    chk("R9 disabled zone reached in fixed", zone_o, 1);
    chk("R11 zone 1 mask", pwm_en, 8'h55);

    // R10: automatic mode held at 0 before nominal
    lim3 = 8'hA0;
    mode_in = 2'b01; v_nominal = 1'b0; i_sample = 8'h20;
    do_reset();
    tick_n(6);
    chk("R10 no shedding before nominal", zone_o, 0);
    chk("R12 dcm off", dcm_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule